// File: doc/BRIEF.md
# Watchdog Register Front End with Keyed Write Protection

This block sits between a simple synchronous register bus and the countdown core of a watchdog timer. It owns the 16-byte register window through which software reloads the timer, loads the two stage preload values and clears the flag that records a watchdog-caused restart. Any write that could change the timer's behaviour must follow a two-write key sequence. The first key is 0x80 and the second is 0x86, and both are written to offset 0xC. A completed sequence arms the block for exactly one protected write. The next qualifying write uses up the armed state, even when that write has no effect.

Two further registers are reached through separate write ports. The first is a configuration register that sets the reboot policy, the clock scale and the interrupt type. The second is a control register that holds the enable and free-run bits and a sticky lock bit. Once the lock bit is set, the control register cannot change again until reset. The block only drives level and pulse controls into the timer core. The countdown itself lives in that core.

Top module: `wdt_regfront`

## Requirements
- R1: After reset, both preload outputs are 0xFFFFF, reboot_en is 1, fast_scale is 0, irq_type is 0, wd_enable, wd_free_run and wd_locked are 0, and neither pulse output is active.
- R2: A bus write whose size-masked data equals 0x80 at offset 0xC, followed by a write of 0x86 at offset 0xC, arms the block. Size codes are 0 for byte, 1 for half-word and 2 for word.
- R3: When the block is not armed, no bus write changes a preload or raises wd_kick or wd_flag_clr. This includes a write of 0x86 that was not preceded by 0x80.
- R4: While armed, the first half-word or word write that is not a key write returns the block to idle, at any offset. A second protected write then needs a new key sequence.
- R5: An armed word write to offset 0x0 loads t1_preload, and one to offset 0x4 loads t2_preload. Each takes bits 19:0 of the write data, and the new value appears the cycle after the write.
- R6: An armed half-word write to offset 0xC with data bit 8 set gives a one-cycle wd_kick pulse in the cycle after the write.
- R7: An armed half-word write to offset 0xC with data bit 9 or bit 12 set gives a one-cycle wd_flag_clr pulse in the cycle after the write.
- R8: Byte writes never perform a protected action and never use up the armed state. A byte write of 0x80 at offset 0xC still restarts the key sequence.
- R9: A half-word read of offset 0xC returns core_prev_flag on bits 9 and 12, with all other bits 0. Every other read returns 0. Read data is valid in the cycle after bus_re.
- R10: A configuration write sets reboot_en to the inverse of bit 5, fast_scale to bit 2 and irq_type to bits 1:0.
- R11: A control write sets wd_locked from bit 0, wd_enable from bit 1 and wd_free_run from bit 2. While wd_locked is 1, control writes are ignored until reset.
- R12: A write of 0x80 at offset 0xC restarts the sequence from its first step in every state, including the armed state, and leaves the block unarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_re | input | 1 | Single-cycle read strobe |
| bus_addr | input | 4 | Byte offset in the window |
| bus_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| bus_wdata | input | 32 | Write data, right aligned |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_re |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| lock_we | input | 1 | Control register write strobe |
| lock_wdata | input | 8 | Control write data |
| core_prev_flag | input | 1 | Previous-restart flag held in the timer core |
| t1_preload | output | 20 | First-stage preload |
| t2_preload | output | 20 | Second-stage preload |
| wd_kick | output | 1 | Keepalive pulse to the core |
| wd_flag_clr | output | 1 | Pulse that clears the core's restart flag |
| wd_enable | output | 1 | Watchdog enable |
| wd_free_run | output | 1 | Restart stage one after final expiry |
| wd_locked | output | 1 | Control register frozen |
| reboot_en | output | 1 | Final expiry causes a restart |
| fast_scale | output | 1 | Fast decrement clock selected |
| irq_type | output | 2 | First-stage interrupt type |

## Verification
The assertions assume a few things about the bus. Only one of bus_we and bus_re is high in any cycle, bus_size never takes the reserved code 3, and bus_addr is word aligned. The random stimulus draws offsets only from 0x0, 0x4, 0x8 and 0xC, draws sizes only from the three defined codes, and issues one strobe per operation. About a third of the random write data values are forced to the two key values, so that armed states and half-finished sequences occur often. Directed cases cover key misuse, restarts of the sequence from the armed state, byte writes while armed, and the sticky lock across a reset.

// File: rtl/wdt_rf_pkg.sv
package wdt_rf_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_RSVD = 2'b11
   } bus_size_e;

   typedef enum logic [1:0] {
      UL_IDLE  = 2'd0,
      UL_HALF  = 2'd1,
      UL_ARMED = 2'd2
   } unlock_e;

   localparam int KICK_BIT   = 8;
   localparam int FLAG_BIT_A = 9;
   localparam int FLAG_BIT_B = 12;

endpackage

// File: rtl/wdt_rf_unlock.sv
module wdt_rf_unlock
   import wdt_rf_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 4,
   parameter int KEY_OFFS = 12,
   parameter int KEY_ONE  = 'h80,
   parameter int KEY_TWO  = 'h86
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   input  logic [DATA_W-1:0] wdata,
   output logic              armed,
   output logic              consume
);

   localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(KEY_OFFS);
   localparam logic [DATA_W-1:0] K1    = DATA_W'(KEY_ONE);
   localparam logic [DATA_W-1:0] K2    = DATA_W'(KEY_TWO);

   unlock_e           state_q, state_d;
   logic [DATA_W-1:0] lane_val;
   logic              key1_hit, key2_hit;

   always_comb begin
      case (size)
         SZ_BYTE: lane_val = {{(DATA_W-8){1'b0}}, wdata[7:0]};
         SZ_HALF: lane_val = {{(DATA_W-16){1'b0}}, wdata[15:0]};
         default: lane_val = wdata;
      endcase
   end

   assign key1_hit = we && (addr == KEY_A) && (lane_val == K1);
   assign key2_hit = we && (addr == KEY_A) && (lane_val == K2) && (state_q == UL_HALF);
   assign consume  = we && !key1_hit && !key2_hit && (state_q == UL_ARMED)
                     && (size != SZ_BYTE);

   always_comb begin
      state_d = state_q;
      if (key1_hit)      state_d = UL_HALF;
      else if (key2_hit) state_d = UL_ARMED;
      else if (consume)  state_d = UL_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= UL_IDLE;
      else        state_q <= state_d;
   end

   assign armed = (state_q == UL_ARMED);

endmodule

// File: rtl/wdt_rf_protregs.sv
module wdt_rf_protregs
   import wdt_rf_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 4,
   parameter int PRELOAD_W   = 20,
   parameter int PRELOAD_RST = 'hFFFFF,
   parameter int T1_OFFS     = 0,
   parameter int T2_OFFS     = 4,
   parameter int KEY_OFFS    = 12
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            consume,
   input  logic [ADDR_W-1:0]               addr,
   input  logic [1:0]                      size,
   input  logic [DATA_W-1:0]               wdata,
   output logic [1:0][PRELOAD_W-1:0]       preload,
   output logic                            kick,
   output logic                            flag_clr
);

   localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(KEY_OFFS);

   for (genvar g = 0; g < 2; g++) begin : g_pre
      localparam logic [ADDR_W-1:0] OFFS = ADDR_W'((g == 0) ? T1_OFFS : T2_OFFS);
      logic [PRELOAD_W-1:0] pre_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            pre_q <= PRELOAD_W'(PRELOAD_RST);
         else if (consume && (size == SZ_WORD) && (addr == OFFS))
            pre_q <= wdata[PRELOAD_W-1:0];
      end
      assign preload[g] = pre_q;
   end

   logic half_hit;
   logic kick_q, clr_q;

   assign half_hit = consume && (size == SZ_HALF) && (addr == KEY_A);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kick_q <= 1'b0;
         clr_q  <= 1'b0;
      end else begin
         kick_q <= half_hit && wdata[KICK_BIT];
         clr_q  <= half_hit && (wdata[FLAG_BIT_A] || wdata[FLAG_BIT_B]);
      end
   end

   assign kick     = kick_q;
   assign flag_clr = clr_q;

endmodule

// File: rtl/wdt_rf_ctlregs.sv
module wdt_rf_ctlregs #(
   parameter int CFG_W        = 16,
   parameter int LOCK_W       = 8,
   parameter int NOREBOOT_BIT = 5,
   parameter int FAST_BIT     = 2,
   parameter int IRQ_LSB      = 0,
   parameter int LOCK_BIT     = 0,
   parameter int EN_BIT       = 1,
   parameter int FREE_BIT     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              lock_we,
   input  logic [LOCK_W-1:0] lock_wdata,
   output logic              reboot_en,
   output logic              fast_scale,
   output logic [1:0]        irq_type,
   output logic              locked,
   output logic              enable,
   output logic              free_run
);

   logic       reb_q, fast_q, lock_q, en_q, free_q;
   logic [1:0] irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reb_q  <= 1'b1;
         fast_q <= 1'b0;
         irq_q  <= 2'd0;
      end else if (cfg_we) begin
         reb_q  <= !cfg_wdata[NOREBOOT_BIT];
         fast_q <= cfg_wdata[FAST_BIT];
         irq_q  <= cfg_wdata[IRQ_LSB +: 2];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
         en_q   <= 1'b0;
         free_q <= 1'b0;
      end else if (lock_we && !lock_q) begin
         lock_q <= lock_wdata[LOCK_BIT];
         en_q   <= lock_wdata[EN_BIT];
         free_q <= lock_wdata[FREE_BIT];
      end
   end

   assign reboot_en  = reb_q;
   assign fast_scale = fast_q;
   assign irq_type   = irq_q;
   assign locked     = lock_q;
   assign enable     = en_q;
   assign free_run   = free_q;

endmodule

// File: rtl/wdt_regfront.sv
module wdt_regfront
   import wdt_rf_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 4,
   parameter int PRELOAD_W   = 20,
   parameter int PRELOAD_RST = 'hFFFFF,
   parameter int CFG_W       = 16,
   parameter int LOCK_W      = 8,
   parameter int T1_OFFS     = 0,
   parameter int T2_OFFS     = 4,
   parameter int KEY_OFFS    = 12,
   parameter int KEY_ONE     = 'h80,
   parameter int KEY_TWO     = 'h86,
   parameter bit RDATA_REG   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_we,
   input  logic                 bus_re,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [1:0]           bus_size,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic                 cfg_we,
   input  logic [CFG_W-1:0]     cfg_wdata,
   input  logic                 lock_we,
   input  logic [LOCK_W-1:0]    lock_wdata,
   input  logic                 core_prev_flag,
   output logic [PRELOAD_W-1:0] t1_preload,
   output logic [PRELOAD_W-1:0] t2_preload,
   output logic                 wd_kick,
   output logic                 wd_flag_clr,
   output logic                 wd_enable,
   output logic                 wd_free_run,
   output logic                 wd_locked,
   output logic                 reboot_en,
   output logic                 fast_scale,
   output logic [1:0]           irq_type
);

   localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(KEY_OFFS);

   if (DATA_W < 16) begin : g_chk_data
      $error("wdt_regfront: DATA_W must be at least 16");
   end
   if (PRELOAD_W > DATA_W) begin : g_chk_pre
      $error("wdt_regfront: PRELOAD_W must not exceed DATA_W");
   end
   if ((1 << ADDR_W) <= KEY_OFFS) begin : g_chk_addr
      $error("wdt_regfront: ADDR_W too small for the key offset");
   end
   if (CFG_W < 6 || LOCK_W < 3) begin : g_chk_ctl
      $error("wdt_regfront: control register widths too small");
   end

   logic                       armed;
   logic                       consume;
   logic [1:0][PRELOAD_W-1:0]  preload;

   wdt_rf_unlock #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .KEY_OFFS(KEY_OFFS),
      .KEY_ONE(KEY_ONE), .KEY_TWO(KEY_TWO)
   ) i_unlock (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
      .size(bus_size), .wdata(bus_wdata), .armed(armed), .consume(consume)
   );

   wdt_rf_protregs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRELOAD_W(PRELOAD_W),
      .PRELOAD_RST(PRELOAD_RST), .T1_OFFS(T1_OFFS), .T2_OFFS(T2_OFFS),
      .KEY_OFFS(KEY_OFFS)
   ) i_prot (
      .clk(clk), .rst_n(rst_n), .consume(consume), .addr(bus_addr),
      .size(bus_size), .wdata(bus_wdata), .preload(preload),
      .kick(wd_kick), .flag_clr(wd_flag_clr)
   );

   wdt_rf_ctlregs #(
      .CFG_W(CFG_W), .LOCK_W(LOCK_W)
   ) i_ctl (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .lock_we(lock_we), .lock_wdata(lock_wdata), .reboot_en(reboot_en),
      .fast_scale(fast_scale), .irq_type(irq_type), .locked(wd_locked),
      .enable(wd_enable), .free_run(wd_free_run)
   );

   assign t1_preload = preload[0];
   assign t2_preload = preload[1];

   logic              rd_hit;
   logic [DATA_W-1:0] rd_val;

   assign rd_hit = bus_re && (bus_size == SZ_HALF) && (bus_addr == KEY_A);

   always_comb begin
      rd_val = '0;
      if (rd_hit) begin
         rd_val[FLAG_BIT_A] = core_prev_flag;
         rd_val[FLAG_BIT_B] = core_prev_flag;
      end
   end

   if (RDATA_REG) begin : g_rd_reg
      logic [DATA_W-1:0] rdata_q;
      always_ff @(posedge clk) begin
         if (!rst_n) rdata_q <= '0;
         else        rdata_q <= rd_val;
      end
      assign bus_rdata = rdata_q;
   end else begin : g_rd_comb
      assign bus_rdata = rd_val;
   end

endmodule

// File: rtl/wdt_regfront_chk.sv
module wdt_regfront_chk
   import wdt_rf_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 4,
   parameter int PRELOAD_W = 20,
   parameter int KEY_OFFS  = 12,
   parameter int KEY_ONE   = 'h80,
   parameter bit RDATA_REG = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_we,
   input logic                 bus_re,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic [1:0]           bus_size,
   input logic [DATA_W-1:0]    bus_wdata,
   input logic [DATA_W-1:0]    bus_rdata,
   input logic                 armed,
   input logic [PRELOAD_W-1:0] t1_preload,
   input logic                 wd_kick,
   input logic                 wd_enable,
   input logic                 wd_free_run,
   input logic                 wd_locked
);

   localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(KEY_OFFS);

   p_kick_needs_key_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wd_kick |-> $past(armed && bus_we && bus_size == SZ_HALF && bus_addr == KEY_A));

   p_kick_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wd_kick |=> !wd_kick);

   p_preload_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (t1_preload != $past(t1_preload)) |-> $past(armed && bus_we && bus_size == SZ_WORD));

   p_byte_keeps_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && bus_we && bus_size == SZ_BYTE &&
       !(bus_addr == KEY_A && bus_wdata[7:0] == 8'(KEY_ONE))) |=> armed);

   p_key_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == KEY_A && bus_size == SZ_WORD &&
       bus_wdata == DATA_W'(KEY_ONE)) |=> !armed);

   p_lock_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wd_locked |=> wd_locked);

   p_lock_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wd_locked |=> ($stable(wd_enable) && $stable(wd_free_run)));

   if (RDATA_REG) begin : g_rd
      p_rdata_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_re && !(bus_size == SZ_HALF && bus_addr == KEY_A)) |=> (bus_rdata == '0));
   end

endmodule

bind wdt_regfront wdt_regfront_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRELOAD_W(PRELOAD_W),
   .KEY_OFFS(KEY_OFFS), .KEY_ONE(KEY_ONE), .RDATA_REG(RDATA_REG)
) i_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
   .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata), .armed(armed), .t1_preload(t1_preload),
   .wd_kick(wd_kick), .wd_enable(wd_enable), .wd_free_run(wd_free_run),
   .wd_locked(wd_locked)
);

// File: tb/test_wdt_regfront.sv
`timescale 1ns/1ps
module test_wdt_regfront;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0, bus_re = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [1:0]  bus_size = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        cfg_we = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic        lock_we = 1'b0;
   logic [7:0]  lock_wdata = '0;
   logic        core_prev_flag = 1'b0;
   logic [19:0] t1_preload, t2_preload;
   logic        wd_kick, wd_flag_clr, wd_enable, wd_free_run, wd_locked;
   logic        reboot_en, fast_scale;
   logic [1:0]  irq_type;

   always #2.5 clk = ~clk;

   wdt_regfront i_wdt_regfront (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
      .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .lock_we(lock_we), .lock_wdata(lock_wdata), .core_prev_flag(core_prev_flag),
      .t1_preload(t1_preload), .t2_preload(t2_preload), .wd_kick(wd_kick),
      .wd_flag_clr(wd_flag_clr), .wd_enable(wd_enable), .wd_free_run(wd_free_run),
      .wd_locked(wd_locked), .reboot_en(reboot_en), .fast_scale(fast_scale),
      .irq_type(irq_type)
   );

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   // reference state derived from the requirements
   int          m_ul;
   logic [19:0] m_t1, m_t2;
   logic        m_kick, m_clr, m_reb, m_fast, m_lock, m_en, m_free;
   logic [1:0]  m_irq;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_all(input string req);
      chk(t1_preload == m_t1, req, 32'(t1_preload), 32'(m_t1));
      chk(t2_preload == m_t2, req, 32'(t2_preload), 32'(m_t2));
      chk(wd_kick == m_kick, req, 32'(wd_kick), 32'(m_kick));
      chk(wd_flag_clr == m_clr, req, 32'(wd_flag_clr), 32'(m_clr));
      chk({reboot_en, fast_scale, irq_type} == {m_reb, m_fast, m_irq}, req,
          32'({reboot_en, fast_scale, irq_type}), 32'({m_reb, m_fast, m_irq}));
      chk({wd_locked, wd_enable, wd_free_run} == {m_lock, m_en, m_free}, req,
          32'({wd_locked, wd_enable, wd_free_run}), 32'({m_lock, m_en, m_free}));
   endtask

   function automatic logic [31:0] lane(input logic [31:0] d, input logic [1:0] sz);
      if (sz == 2'd0) return {24'd0, d[7:0]};
      if (sz == 2'd1) return {16'd0, d[15:0]};
      return d;
   endfunction

   task automatic model_reset();
      m_ul = 0; m_t1 = 20'hFFFFF; m_t2 = 20'hFFFFF; m_kick = 0; m_clr = 0;
      m_reb = 1; m_fast = 0; m_irq = 0; m_lock = 0; m_en = 0; m_free = 0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();
   endtask

   task automatic bus_wr(input logic [3:0] a, input logic [31:0] d, input logic [1:0] sz, input string req);
      logic [31:0] v;
      bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b0;
      v = lane(d, sz);
      m_kick = 0; m_clr = 0;
      if (a == 4'hC && v == 32'h80) m_ul = 1;
      else if (a == 4'hC && v == 32'h86 && m_ul == 1) m_ul = 2;
      else if (m_ul == 2 && sz != 2'd0) begin
         if (sz == 2'd2 && a == 4'h0) m_t1 = d[19:0];
         if (sz == 2'd2 && a == 4'h4) m_t2 = d[19:0];
         if (sz == 2'd1 && a == 4'hC) begin
            m_kick = d[8];
            m_clr  = d[9] | d[12];
         end
         m_ul = 0;
      end
      check_all(req);
   endtask

   task automatic unlock();
      bus_wr(4'hC, 32'h80, 2'd1, "R2");
      bus_wr(4'hC, 32'h86, 2'd1, "R2");
   endtask

   task automatic bus_rd(input logic [3:0] a, input logic [1:0] sz, input logic flag, input string req);
      logic [31:0] e;
      bus_re = 1'b1; bus_addr = a; bus_size = sz; core_prev_flag = flag;
      @(posedge clk);
      @(negedge clk);
      bus_re = 1'b0;
      m_kick = 0; m_clr = 0;
      e = (sz == 2'd1 && a == 4'hC) ? ((32'(flag) << 9) | (32'(flag) << 12)) : 32'd0;
      chk(bus_rdata == e, req, bus_rdata, e);
   endtask

   task automatic cfg_wr(input logic [15:0] d);
      cfg_we = 1'b1; cfg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      cfg_we = 1'b0;
      m_kick = 0; m_clr = 0;
      m_reb = !d[5]; m_fast = d[2]; m_irq = d[1:0];
      check_all("R10");
   endtask

   task automatic lock_wr(input logic [7:0] d);
      lock_we = 1'b1; lock_wdata = d;
      @(posedge clk);
      @(negedge clk);
      lock_we = 1'b0;
      m_kick = 0; m_clr = 0;
      if (!m_lock) begin
         m_lock = d[0]; m_en = d[1]; m_free = d[2];
      end
      check_all("R11");
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = 32'h5eed;
      void'($urandom(seed));
      model_reset();
      do_reset();
      check_all("R1");
      chk(bus_rdata == 0, "R1", bus_rdata, 0);

      // R3: no key, wrong key order
      bus_wr(4'h0, 32'h00012345, 2'd2, "R3");
      bus_wr(4'hC, 32'h86, 2'd1, "R3");
      bus_wr(4'h4, 32'h00055555, 2'd2, "R3");
      bus_wr(4'hC, 32'h0100, 2'd1, "R3");

      // R5: masked preload loads
      unlock();
      bus_wr(4'h0, 32'hABC12345, 2'd2, "R5");
      unlock();
      bus_wr(4'h4, 32'hFFF0000F, 2'd2, "R5");

      // R4: single use, consumed by any address
      bus_wr(4'h0, 32'h00000001, 2'd2, "R4");
      unlock();
      bus_wr(4'h8, 32'h00000777, 2'd1, "R4");
      bus_wr(4'h4, 32'h00000abc, 2'd2, "R4");

      // R8: byte writes neither act nor consume
      unlock();
      bus_wr(4'hC, 32'h00000001, 2'd0, "R8");
      bus_wr(4'h0, 32'h000000FF, 2'd0, "R8");
      bus_wr(4'h4, 32'h00013579, 2'd2, "R8");

      // R6 / R7: keepalive and flag clear pulses
      unlock();
      bus_wr(4'hC, 32'h0100, 2'd1, "R6");
      check_all("R6");
      unlock();
      bus_wr(4'hC, 32'h1000, 2'd1, "R7");
      unlock();
      bus_wr(4'hC, 32'h0200, 2'd1, "R7");
      unlock();
      bus_wr(4'hC, 32'h0100, 2'd2, "R6");

      // R12: first key restarts from the armed state
      unlock();
      bus_wr(4'hC, 32'h80, 2'd2, "R12");
      bus_wr(4'h0, 32'h00000042, 2'd2, "R12");
      bus_wr(4'hC, 32'h80, 2'd0, "R12");
      bus_wr(4'hC, 32'h86, 2'd2, "R12");
      bus_wr(4'h0, 32'h00000042, 2'd2, "R12");

      // R9: reads
      bus_rd(4'hC, 2'd1, 1'b1, "R9");
      bus_rd(4'hC, 2'd1, 1'b0, "R9");
      bus_rd(4'hC, 2'd2, 1'b1, "R9");
      bus_rd(4'h8, 2'd1, 1'b1, "R9");
      bus_rd(4'h0, 2'd0, 1'b1, "R9");

      // R10: configuration fields
      cfg_wr(16'h0020);
      cfg_wr(16'h0007);
      cfg_wr(16'h0002);

      // R11: lock register
      lock_wr(8'h06);
      lock_wr(8'h00);
      lock_wr(8'h07);
      lock_wr(8'h00);
      lock_wr(8'h02);
      do_reset();
      check_all("R1");

      // random mix
      for (int i = 0; i < 600; i++) begin
         int op;
         logic [3:0]  a;
         logic [1:0]  sz;
         logic [31:0] d;
         op = $urandom_range(0, 9);
         a  = 4'($urandom_range(0, 3) * 4);
         sz = 2'($urandom_range(0, 2));
         d  = $urandom();
         if ($urandom_range(0, 2) == 0) begin
            a = 4'hC;
            d = ($urandom_range(0, 1) == 0) ? 32'h80 : 32'h86;
         end
         if (op < 6)      bus_wr(a, d, sz, "R4");
         else if (op < 8) bus_rd(a, sz, 1'($urandom_range(0, 1)), "R9");
         else if (op < 9) cfg_wr(16'(d));
         else             lock_wr(8'(d));
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule